// File: doc/BRIEF.md
# Lookup-Table Constant Multiplier

This block multiplies an unsigned input word by a constant that is fixed when the design is built. It uses no array multiplier. The input is cut into 4-bit nibbles. Each nibble selects one of sixteen stored multiples of the constant, from zero times to fifteen times. The stored multiples are computed at elaboration from the constant parameter. The partial product of a higher nibble is shifted left by four bits per nibble position. All partial products are then summed into the full-width product. With the default sizes, an 8-bit input gives two 12-bit partial products and a 16-bit result.

The data path has two registered stages: a table-read stage and an add stage. Both the input and output sides use a valid/ready handshake. A word is accepted on any clock edge where `in_valid` and `in_ready` are both high. A product leaves on any edge where `out_valid` and `out_ready` are both high.

Back-pressure moves upstream one stage at a time:
- A stage can load a new word only when it is empty or when its own word is leaving on the same edge.
- When `out_ready` is low, a waiting product keeps its value.
- While `out_ready` stays low, the pipeline keeps accepting input until both stages hold a word. Then `in_ready` drops.

Whenever `out_ready` is high, the block accepts a new word on every cycle.

Top module: `const_coef_mult`

## Requirements
- R1: With the high nibble at zero, an input x from 0 to 15 gives exactly x times the constant. Each low-nibble table entry i holds i times the constant.
- R2: With the low nibble at zero, an input gives 16 times (high nibble times the constant). The high-nibble partial product is shifted left by 4 bits, and the zero-extended low partial product adds to it.
- R3: Every product equals the input times the constant as an exact 16-bit value, with no overflow. An input of 255 times a constant of 255 gives 65025.
- R4: When `out_ready` is high on the accept edge and on the next edge, `out_valid` carrying that word's product is high after the second rising edge. The latency is 2 cycles.
- R5: Whenever `out_ready` is high, `in_ready` is high, so a word can be accepted every cycle.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_prod` holds its value on the next cycle.
- R7: With two words inside the block and `out_ready` low, `in_ready` is low. With fewer than two words inside, `in_ready` is high. Products leave in acceptance order, and none is lost or duplicated.
- R8: During and right after synchronous reset (`rst` high), `out_valid` is 0 and `in_ready` is 1.
- R9: While `in_valid` is low, `in_data` has no effect. No product appears for it, whatever the value on `in_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | 8 | Unsigned multiplicand |
| out_valid | output | 1 | Product present |
| out_ready | input | 1 | Consumer takes the product this cycle |
| out_prod | output | 16 | Input times the constant |

## Verification
The bench sets the constant to 255 so that the largest product, 65025, falls within the runs.

Directed inputs test each half of the data path on its own:
- Values 0 to 15 exercise only the low-nibble table.
- Multiples of 16 exercise only the shifted high-nibble path. A wrong shift amount or a wrong table entry shows up here.

All-ones and alternating bit patterns check that the carries between the two partial products come out right. Long random streams, with random gaps on the input and random stalls on the output, check the ordering and the holding behaviour under back-pressure. A final idle stretch, with `in_data` changing while `in_valid` is low, must produce no output.

// File: rtl/ccm_pkg.sv
package ccm_pkg;
  // multiple of the constant stored at a given table index
  function automatic int unsigned table_entry(input int unsigned idx,
                                              input int unsigned coef);
    return idx * coef;
  endfunction
endpackage

// File: rtl/ccm_table.sv
module ccm_table #(
  parameter int unsigned NIB_W = 4,
  parameter int unsigned COEF_W = 8,
  parameter int unsigned COEF = 181,
  localparam int unsigned PP_W = NIB_W + COEF_W,
  localparam int unsigned DEPTH = 1 << NIB_W
) (
  input  logic [NIB_W-1:0] addr,
  output logic [PP_W-1:0]  entry
);
  logic [PP_W-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    assign rom[i] = PP_W'(ccm_pkg::table_entry(i, COEF));
  end

  assign entry = rom[addr];
endmodule

// File: rtl/ccm_fetch_stage.sv
module ccm_fetch_stage #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NIB_W = 4,
  parameter int unsigned COEF_W = 8,
  parameter int unsigned COEF = 181,
  localparam int unsigned NIBS = DATA_W / NIB_W,
  localparam int unsigned PP_W = NIB_W + COEF_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [DATA_W-1:0]          in_data,
  input  logic                       next_ready,
  output logic                       stage_ready,
  output logic                       pp_valid,
  output logic [NIBS-1:0][PP_W-1:0]  pp
);
  logic [NIBS-1:0][PP_W-1:0] lookup;

  for (genvar k = 0; k < NIBS; k++) begin : g_nib
    ccm_table #(.NIB_W(NIB_W), .COEF_W(COEF_W), .COEF(COEF)) u_table (
      .addr  (in_data[k*NIB_W +: NIB_W]),
      .entry (lookup[k])
    );
  end

  assign stage_ready = !pp_valid || next_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pp_valid <= 1'b0;
      pp       <= '0;
    end else if (stage_ready) begin
      pp_valid <= in_valid;
      if (in_valid) pp <= lookup;
    end
  end
endmodule

// File: rtl/ccm_sum_stage.sv
module ccm_sum_stage #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NIB_W = 4,
  parameter int unsigned COEF_W = 8,
  localparam int unsigned NIBS = DATA_W / NIB_W,
  localparam int unsigned PP_W = NIB_W + COEF_W,
  localparam int unsigned PROD_W = DATA_W + COEF_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       pp_valid,
  input  logic [NIBS-1:0][PP_W-1:0]  pp,
  input  logic                       out_ready,
  output logic                       stage_ready,
  output logic                       out_valid,
  output logic [PROD_W-1:0]          out_prod
);
  logic [PROD_W-1:0] total;

  always_comb begin
    total = '0;
    for (int k = 0; k < NIBS; k++) begin
      total = total + (PROD_W'(pp[k]) << (k * NIB_W));
    end
  end

  assign stage_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_prod  <= '0;
    end else if (stage_ready) begin
      out_valid <= pp_valid;
      if (pp_valid) out_prod <= total;
    end
  end
endmodule

// File: rtl/const_coef_mult.sv
module const_coef_mult #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NIB_W = 4,
  parameter int unsigned COEF_W = 8,
  parameter int unsigned COEF = 181,
  localparam int unsigned NIBS = DATA_W / NIB_W,
  localparam int unsigned PP_W = NIB_W + COEF_W,
  localparam int unsigned PROD_W = DATA_W + COEF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PROD_W-1:0] out_prod
);
  logic                      pp_valid;
  logic [NIBS-1:0][PP_W-1:0] pp;
  logic                      sum_ready;

  ccm_fetch_stage #(.DATA_W(DATA_W), .NIB_W(NIB_W), .COEF_W(COEF_W), .COEF(COEF)) u_fetch (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .next_ready  (sum_ready),
    .stage_ready (in_ready),
    .pp_valid    (pp_valid),
    .pp          (pp)
  );

  ccm_sum_stage #(.DATA_W(DATA_W), .NIB_W(NIB_W), .COEF_W(COEF_W)) u_sum (
    .clk         (clk),
    .rst         (rst),
    .pp_valid    (pp_valid),
    .pp          (pp),
    .out_ready   (out_ready),
    .stage_ready (sum_ready),
    .out_valid   (out_valid),
    .out_prod    (out_prod)
  );
endmodule

// File: rtl/const_coef_mult_chk.sv
module const_coef_mult_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned COEF_W = 8,
  parameter int unsigned COEF = 181,
  localparam int unsigned PROD_W = DATA_W + COEF_W
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PROD_W-1:0] out_prod
);
  localparam logic [PROD_W-1:0] MAX_PROD =
    PROD_W'(((1 << DATA_W) - 1) * COEF);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R8
  always @(posedge clk) begin
    if (!rst && rst_q) begin
      reset_state_chk: assert (!out_valid && in_ready);
    end
  end

  // R6
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_prod));

  // R5
  full_rate_chk: assert property (@(posedge clk) disable iff (rst)
    out_ready |-> in_ready);

  // R4
  two_cycle_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && out_ready) ##1 out_ready |=> out_valid);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_prod <= MAX_PROD);
endmodule

bind const_coef_mult const_coef_mult_chk #(
  .DATA_W(DATA_W), .COEF_W(COEF_W), .COEF(COEF)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_prod(out_prod)
);

// File: tb/const_coef_mult_tb.sv
module const_coef_mult_tb;
  localparam int CLK_PERIOD = 10;
  localparam int unsigned COEF = 255;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_prod;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  string       cur_tag = "R3";
  bit          prev_stall = 0;
  logic [15:0] prev_prod = '0;

  const_coef_mult #(.COEF(COEF)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_prod(out_prod)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] ref_prod(input logic [7:0] x);
    return 16'(int'(x) * int'(COEF));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: sampled at the falling edge, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (prev_stall)  // R6
        check(out_valid && out_prod == prev_prod, "R6", int'(out_prod), int'(prev_prod));
      if (out_ready)   // R5
        check(in_ready, "R5", int'(in_ready), 1);
      else             // R7
        check(in_ready == (exp_q.size() < 2), "R7", int'(in_ready), int'(exp_q.size() < 2));
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R7", int'(out_prod), -1);
        end else begin
          automatic logic [15:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(out_prod == e, t, int'(out_prod), int'(e));
        end
      end
      if (in_valid && in_ready) begin
        exp_q.push_back(ref_prod(in_data));
        tag_q.push_back(cur_tag);
      end
      prev_stall = out_valid && !out_ready;
      prev_prod  = out_prod;
    end
  end

  task automatic send(input logic [7:0] x, input string tag);
    cur_tag  = tag;
    in_valid = 1'b1;
    in_data  = x;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    out_ready = 1'b1;
    repeat (6) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: state while reset is held
    check(!out_valid && in_ready, "R8", int'(out_valid), 0);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && in_ready, "R8", int'(out_valid), 0);
    @(posedge clk); #1;

    // R1: low nibble only
    for (int i = 0; i < 16; i++) send(8'(i), "R1");
    drain();
    // R2: high nibble only
    for (int i = 0; i < 16; i++) send(8'(i << 4), "R2");
    drain();
    // R3: carry-heavy corners
    send(8'hFF, "R3"); send(8'hAA, "R3"); send(8'h55, "R3");
    send(8'h0F, "R3"); send(8'hF0, "R3"); send(8'h81, "R3");
    drain();

    // R4: latency with out_ready high
    out_ready = 1'b1;
    cur_tag = "R4";
    in_valid = 1'b1; in_data = 8'd77;
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    check(!out_valid, "R4", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid && out_prod == ref_prod(8'd77), "R4", int'(out_prod), int'(ref_prod(8'd77)));
    drain();

    // R7: fill under stall, then release
    out_ready = 1'b0;
    send(8'd3, "R7"); send(8'd200, "R7");
    in_valid = 1'b1; in_data = 8'd9; cur_tag = "R7";
    repeat (4) @(negedge clk);
    check(!in_ready, "R7", int'(in_ready), 0);
    out_ready = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
    drain();

    // R3/R6/R7: random stream with gaps and stalls
    void'($urandom(32'd1234));
    cur_tag = "R3";
    for (int n = 0; n < 4000; n++) begin
      in_valid  = ($urandom % 10) < 7;
      in_data   = 8'($urandom);
      if (($urandom % 16) == 0) in_data = 8'hFF;
      out_ready = ($urandom % 10) < 7;
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    drain();
    check(exp_q.size() == 0, "R7", exp_q.size(), 0);

    // R9: data toggles with in_valid low
    out_ready = 1'b1;
    for (int n = 0; n < 12; n++) begin
      in_data = 8'($urandom);
      @(negedge clk);
      check(!out_valid, "R9", int'(out_valid), 0);
      @(posedge clk); #1;
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule